// File: doc/BRIEF.md
# Dual Elapsed-Time Counter Core

This core keeps two 32-bit binary seconds counters that share a one-cycle tick strobe. The always-on counter advances on every tick. The supply-gated counter advances only on a tick that arrives while the supply-present input is high, and it keeps its value while supply is absent. Both counters wrap silently from all ones to zero.

A serial front end, which is not part of this core, drives the core through one-cycle strobes. A capture strobe copies the selected counter into a holding register, so a slow readout sees a value that does not move. A load strobe writes a full 32-bit word into the selected counter in one cycle. A load takes priority over a tick in the same cycle, and that tick is lost for the loaded counter. Clear requests are only armed while a transfer is open. They take effect together on the strobe that marks the end of the transfer.

Top module: `etc_dual_core`

## Requirements
- R1: After synchronous reset, both counters, the holding register and both armed clear flags are zero.
- R2: The always-on counter increments by one on every cycle with `tick_i` high, whatever the value of `supply_ok_i`.
- R3: The supply-gated counter increments on a tick only when `supply_ok_i` is high. Otherwise it holds its value.
- R4: Each counter wraps from 0xFFFFFFFF to 0 on the next counted tick.
- R5: A cycle with `cap_i` high copies the counter chosen by `sel_i` into `snap_o` on the next edge (sel 0 = always-on, sel 1 = supply-gated). `snap_o` then holds that value until the next capture, even while ticks arrive.
- R6: A cycle with `load_i` high writes `load_data_i` into the counter chosen by `sel_i` on the next edge, using the same encoding as R5. The other counter is unaffected.
- R7: When `load_i` and a countable tick fall in the same cycle, the loaded counter takes `load_data_i` exactly and does not add one. The other counter still counts the tick.
- R8: `clr_on_i` (value 0) and `clr_ss_i` (value 1) arm a clear for the always-on and the supply-gated counter. A clear strobe does nothing to the counters until `xfer_end_i` is pulsed.
- R9: On `xfer_end_i`, every armed counter becomes zero on the next edge. A tick in that cycle is discarded for the cleared counter. All arm flags are then dropped, and an `xfer_end_i` with nothing armed changes no counter except by its tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle 1 Hz seconds strobe |
| supply_ok_i | input | 1 | Main supply present level |
| sel_i | input | 1 | Counter select for capture and load (0 always-on, 1 supply-gated) |
| cap_i | input | 1 | Capture strobe |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 32 | Load value |
| clr_on_i | input | 1 | Arm clear of always-on counter |
| clr_ss_i | input | 1 | Arm clear of supply-gated counter |
| xfer_end_i | input | 1 | End-of-transfer strobe, applies armed clears |
| cnt_on_o | output | 32 | Always-on counter value |
| cnt_ss_o | output | 32 | Supply-gated counter value |
| snap_o | output | 32 | Holding register |

## Verification
The assertions assume that load, capture, clear and transfer-end arrive as one-cycle strobes. They also assume that a load never coincides with a transfer-end that clears the same counter, because the priority between those two is not defined. The directed tasks raise each strobe for exactly one cycle, keep load and transfer-end in separate cycles, and hold `tick_i` low unless a case needs a coincident tick.

// File: rtl/etc_pkg.sv
package etc_pkg;
    localparam int CNT_W = 32;
    localparam int NUM_CNT = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [0:0] {
        SEL_ON = 1'b0,
        SEL_SS = 1'b1
    } cnt_sel_e;

    typedef struct packed {
        logic load;
        logic clear;
        logic count;
        cnt_t data;
    } cnt_ctl_t;

    function automatic cnt_t cnt_next(input cnt_t cur, input cnt_ctl_t c);
        if (c.clear) return '0;
        if (c.load) return c.data;
        if (c.count) return cur + cnt_t'(1);
        return cur;
    endfunction
endpackage

// File: rtl/etc_counter.sv
module etc_counter
    import etc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  cnt_ctl_t ctl_i,
    output cnt_t     val_o
);
    cnt_t val_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) val_q <= '0;
        else       val_q <= cnt_next(val_q, ctl_i);
    end
    assign val_o = val_q;
endmodule

// File: rtl/etc_clear_arm.sv
module etc_clear_arm
    import etc_pkg::*;
#(
    parameter int N = NUM_CNT
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] req_i,
    input  logic         end_i,
    output logic [N-1:0] fire_o,
    output logic [N-1:0] armed_o
);
    logic [N-1:0] armed_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)      armed_q <= '0;
        else if (end_i) armed_q <= '0;
        else            armed_q <= armed_q | req_i;
    end
    assign fire_o  = end_i ? (armed_q | req_i) : '0;
    assign armed_o = armed_q;
endmodule

// File: rtl/etc_dual_core.sv
module etc_dual_core
    import etc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    input  logic        supply_ok_i,
    input  logic        sel_i,
    input  logic        cap_i,
    input  logic        load_i,
    input  logic [31:0] load_data_i,
    input  logic        clr_on_i,
    input  logic        clr_ss_i,
    input  logic        xfer_end_i,
    output logic [31:0] cnt_on_o,
    output logic [31:0] cnt_ss_o,
    output logic [31:0] snap_o
);
    logic [NUM_CNT-1:0] clr_fire, clr_armed;
    logic [NUM_CNT-1:0] cnt_en;
    cnt_t               vals [NUM_CNT];
    cnt_t               snap_q;

    etc_clear_arm #(.N(NUM_CNT)) u_arm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   ({clr_ss_i, clr_on_i}),
        .end_i   (xfer_end_i),
        .fire_o  (clr_fire),
        .armed_o (clr_armed)
    );

    assign cnt_en[SEL_ON] = tick_i;
    assign cnt_en[SEL_SS] = tick_i & supply_ok_i;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        cnt_ctl_t ctl;
        always_comb begin
            ctl.clear = clr_fire[g];
            ctl.load  = load_i && (int'(sel_i) == g);
            ctl.count = cnt_en[g];
            ctl.data  = load_data_i;
        end
        etc_counter u_cnt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .ctl_i (ctl),
            .val_o (vals[g])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)      snap_q <= '0;
        else if (cap_i) snap_q <= vals[sel_i];
    end

    assign cnt_on_o = vals[SEL_ON];
    assign cnt_ss_o = vals[SEL_SS];
    assign snap_o   = snap_q;
endmodule

module etc_dual_core_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        tick_i,
    input logic        supply_ok_i,
    input logic        sel_i,
    input logic        cap_i,
    input logic        load_i,
    input logic [31:0] load_data_i,
    input logic        xfer_end_i,
    input logic [1:0]  clr_armed,
    input logic [31:0] cnt_on_o,
    input logic [31:0] cnt_ss_o,
    input logic [31:0] snap_o
);
    logic started;
    always_ff @(posedge clk_i) started <= rst_i ? 1'b1 : started;

    p_on_count_r2: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        (tick_i && !load_i && !xfer_end_i) |=> cnt_on_o == $past(cnt_on_o) + 32'd1);
    p_ss_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        (!supply_ok_i && !(load_i && sel_i) && !xfer_end_i) |=> $stable(cnt_ss_o));
    p_snap_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        !cap_i |=> $stable(snap_o));
    p_load_r6: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        (load_i && !sel_i && !xfer_end_i) |=> cnt_on_o == $past(load_data_i));
    p_load_prio_r7: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        (load_i && sel_i && !xfer_end_i) |=> cnt_ss_o == $past(load_data_i));
    p_clr_apply_r9: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        (xfer_end_i && clr_armed[0] && !load_i) |=> cnt_on_o == 32'd0);
    p_arm_drop_r9: assert property (@(posedge clk_i) disable iff (rst_i || !started)
        xfer_end_i |=> clr_armed == 2'b00);
    p_reset_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (cnt_on_o == 0 && cnt_ss_o == 0 && snap_o == 0 && clr_armed == 0));
endmodule

bind etc_dual_core etc_dual_core_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .sel_i       (sel_i),
    .cap_i       (cap_i),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .xfer_end_i  (xfer_end_i),
    .clr_armed   (clr_armed),
    .cnt_on_o    (cnt_on_o),
    .cnt_ss_o    (cnt_ss_o),
    .snap_o      (snap_o)
);

// File: tb/tb_etc_dual_core.sv
module tb_etc_dual_core;
    logic        clk = 0;
    logic        rst, tick, supply_ok, sel, cap, load, clr_on, clr_ss, xfer_end;
    logic [31:0] load_data;
    logic [31:0] cnt_on, cnt_ss, snap;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    etc_dual_core dut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .supply_ok_i(supply_ok),
        .sel_i(sel), .cap_i(cap), .load_i(load), .load_data_i(load_data),
        .clr_on_i(clr_on), .clr_ss_i(clr_ss), .xfer_end_i(xfer_end),
        .cnt_on_o(cnt_on), .cnt_ss_o(cnt_ss), .snap_o(snap)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        tick = 0; cap = 0; load = 0; clr_on = 0; clr_ss = 0; xfer_end = 0;
    endtask

    // drive at negedge, then let the posedge register, sample at next negedge
    task automatic step();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic load_cnt(logic s, logic [31:0] v);
        sel = s; load = 1; load_data = v; step();
    endtask

    task automatic t_reset();
        rst = 1; idle(); supply_ok = 0; sel = 0; load_data = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1 on", cnt_on, 0); check("R1 ss", cnt_ss, 0); check("R1 snap", snap, 0);
        xfer_end = 1; step(); // nothing armed after reset
        check("R1 arm", cnt_on | cnt_ss, 0);
    endtask

    task automatic t_gating();
        supply_ok = 1;
        for (int i = 0; i < 3; i++) begin tick = 1; step(); end
        check("R2 on", cnt_on, 3); check("R3 ss on", cnt_ss, 3);
        supply_ok = 0;
        for (int i = 0; i < 2; i++) begin tick = 1; step(); end
        check("R2 on nosupply", cnt_on, 5); check("R3 ss hold", cnt_ss, 3);
        supply_ok = 1;
    endtask

    task automatic t_wrap();
        load_cnt(0, 32'hFFFF_FFFF);
        load_cnt(1, 32'hFFFF_FFFF);
        tick = 1; step();
        check("R4 on", cnt_on, 0); check("R4 ss", cnt_ss, 0);
    endtask

    task automatic t_load();
        load_cnt(0, 32'h1234_5678);
        check("R6 on", cnt_on, 32'h1234_5678); check("R6 other", cnt_ss, 0);
        load_cnt(1, 32'hA5A5_0001);
        check("R6 ss", cnt_ss, 32'hA5A5_0001); check("R6 other2", cnt_on, 32'h1234_5678);
    endtask

    task automatic t_prio();
        sel = 1; load = 1; load_data = 32'h100; tick = 1; step();
        check("R7 loaded", cnt_ss, 32'h100); check("R7 other", cnt_on, 32'h1234_5679);
    endtask

    task automatic t_snap();
        sel = 0; cap = 1; step();
        check("R5 on", snap, 32'h1234_5679);
        tick = 1; step(); tick = 1; step();
        check("R5 hold", snap, 32'h1234_5679);
        sel = 1; cap = 1; step();
        check("R5 ss", snap, 32'h102);
    endtask

    task automatic t_clear();
        clr_on = 1; step();
        tick = 1; step();
        check("R8 deferred", cnt_on, 32'h1234_567C);
        xfer_end = 1; tick = 1; step();
        check("R9 cleared", cnt_on, 0); check("R9 other", cnt_ss, 32'h104);
        xfer_end = 1; step();
        check("R9 disarmed", cnt_on, 0);
        tick = 1; step(); check("R9 counting", cnt_on, 1);
        clr_on = 1; clr_ss = 1; step(); xfer_end = 1; step();
        check("R9 both on", cnt_on, 0); check("R9 both ss", cnt_ss, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset(); t_gating(); t_wrap(); t_load(); t_prio(); t_snap(); t_clear();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule